// File: doc/BRIEF.md
# Cascadable Serial-Load Channel Driver Core

This block is the digital core of a sixteen-channel sink driver for LED displays. A serial bit stream enters on a slow serial clock and data pin and moves through a shift register. The last stage of that register drives a serial output, so several devices can be chained on one data line. A level-sensitive latch bank copies the shift register while the latch-enable input is high and keeps its contents while that input is low. An active-low output enable then passes the latched pattern to sixteen active-high "sink on" signals.

Two protection flags come from analog comparators outside this block. The undervoltage flag switches every channel off and clears all stored bits, so the device comes back empty. The overtemperature flag only blanks the channels. Shifting and latching go on during overtemperature, and the stored pattern shows again when the flag clears. All serial and control pins are sampled by a free-running core clock through two-flop synchronizers. The shift register moves on the rising edge of the synchronized serial clock.

Top module: `ledDrvCore`

## Requirements
- R1: After power-on reset (rstN low), every shift-register stage and every latch bit is 0, so chanOn is 0 and serOut is 0.
- R2: Each rising edge of serClk loads serData into stage 0 and moves every stage k to stage k+1. A pattern P is loaded by shifting P[15] first and P[0] last, so that stage i holds P[i].
- R3: serOut equals the top stage (stage 15) and changes only after a rising edge of serClk. A change on serData alone leaves it unchanged.
- R4: While latchEn is high, the latch bank follows the shift register continuously, so chanOn follows every shift without a new latch pulse.
- R5: While latchEn is low, the latch bank holds its value while new data is shifted in.
- R6: While outEnN is high, every bit of chanOn is 0 and the latch contents are kept. When outEnN returns low, the earlier pattern shows again.
- R7: While outEnN is low and neither protection flag is set, chanOn[i] is 1 exactly when latch bit i is 1.
- R8: While uvFlag is high, chanOn is 0, the shift register ignores serClk, and all stored bits are 0. After uvFlag falls, chanOn and serOut stay 0 until new data is shifted and latched.
- R9: While otFlag is high, chanOn is 0, but shifting and latching continue. When otFlag falls, chanOn shows the pattern held in the latches.
- R10: Every pin input takes effect through a two-flop synchronizer, so each output reflects its inputs within four core-clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running core clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| serClk | input | 1 | Serial shift clock, sampled by clk |
| serData | input | 1 | Serial data in |
| latchEn | input | 1 | Latch bank transparent while high |
| outEnN | input | 1 | Output enable, active low |
| uvFlag | input | 1 | Undervoltage flag from the supply monitor, asynchronous |
| otFlag | input | 1 | Overtemperature flag from the thermal sensor, asynchronous |
| serOut | output | 1 | Top shift stage, feeds the next device in the chain |
| chanOn | output | 16 | Per-channel sink enable, active high, bit i from latch bit i |

## Verification
The assertions assume that serClk, serData, latchEn, outEnN and both flags are slow compared with clk. Each level must hold for at least two core cycles so that the synchronizers see it. serData must also stay stable around each serClk rise. The checker delays outEnN and the flags through its own two-stage chain and predicts blanking from that. For this reason it assumes the default synchronizer depth. The bench drives every pin on the falling edge of clk and holds each level for four core cycles. It waits six cycles before sampling, which is more than the synchronizer and register delay.

// File: rtl/ledDrvPkg.sv
package ledDrvPkg;

  // Strobes from the control unit to the datapath, one per core cycle.
  typedef struct packed {
    logic shift;      // move the shift register one stage
    logic latchOpen;  // latch bank follows the shift register
    logic clearAll;   // force shift register and latches to zero
    logic blank;      // force all channel outputs off
  } ctrlStrobes_t;

endpackage

// File: rtl/ledDrvSync.sv
module ledDrvSync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipe <= '0;
    end else begin
      pipe[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) begin
        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign syncOut = pipe[STAGES-1];

endmodule

// File: rtl/ledDrvCtrl.sv
module ledDrvCtrl
  import ledDrvPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclkS,
  input  logic         leS,
  input  logic         oeNS,
  input  logic         uvS,
  input  logic         otS,
  output ctrlStrobes_t strobes
);

  logic sclkPrev;

  // Edge memory for the synchronized serial clock. It keeps tracking
  // during undervoltage, so a clock held high through recovery gives no
  // false edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= sclkS;
  end

  always_comb begin
    strobes           = '0;
    strobes.clearAll  = uvS;
    strobes.shift     = sclkS && !sclkPrev && !uvS;
    strobes.latchOpen = leS && !uvS;
    strobes.blank     = oeNS || uvS || otS;
  end

endmodule

// File: rtl/ledDrvDatapath.sv
module ledDrvDatapath
  import ledDrvPkg::*;
#(
  parameter int CHANNELS = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic                sdiS,
  output logic [CHANNELS-1:0] stageBits,
  output logic [CHANNELS-1:0] latchBits,
  output logic [CHANNELS-1:0] chanOn
);

  localparam int TOP = CHANNELS - 1;

  logic [CHANNELS-1:0] shiftReg;
  logic [CHANNELS-1:0] latchReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 shiftReg <= '0;
    else if (strobes.clearAll) shiftReg <= '0;
    else if (strobes.shift)    shiftReg <= {shiftReg[TOP-1:0], sdiS};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  latchReg <= '0;
    else if (strobes.clearAll)  latchReg <= '0;
    else if (strobes.latchOpen) latchReg <= shiftReg;
  end

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_gate
    assign chanOn[ch] = latchReg[ch] & ~strobes.blank;
  end

  assign stageBits = shiftReg;
  assign latchBits = latchReg;

endmodule

// File: rtl/ledDrvCore.sv
module ledDrvCore
  import ledDrvPkg::*;
#(
  parameter int CHANNELS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                serClk,
  input  logic                serData,
  input  logic                latchEn,
  input  logic                outEnN,
  input  logic                uvFlag,
  input  logic                otFlag,
  output logic                serOut,
  output logic [CHANNELS-1:0] chanOn
);

  localparam int PINS = 6;

  logic [PINS-1:0]     pinRaw;
  logic [PINS-1:0]     pinSync;
  ctrlStrobes_t        strobes;
  logic [CHANNELS-1:0] stageBits;
  logic [CHANNELS-1:0] latchBits;

  assign pinRaw = {otFlag, uvFlag, outEnN, latchEn, serData, serClk};

  ledDrvSync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (pinRaw),
    .syncOut (pinSync)
  );

  ledDrvCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclkS   (pinSync[0]),
    .leS     (pinSync[2]),
    .oeNS    (pinSync[3]),
    .uvS     (pinSync[4]),
    .otS     (pinSync[5]),
    .strobes (strobes)
  );

  ledDrvDatapath #(.CHANNELS(CHANNELS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .sdiS      (pinSync[1]),
    .stageBits (stageBits),
    .latchBits (latchBits),
    .chanOn    (chanOn)
  );

  assign serOut = stageBits[CHANNELS-1];

endmodule

// File: rtl/ledDrvCoreChk.sv
module ledDrvCoreChk
  import ledDrvPkg::*;
#(
  parameter int CHANNELS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                outEnN,
  input logic                uvFlag,
  input logic                otFlag,
  input logic                serOut,
  input logic [CHANNELS-1:0] chanOn,
  input logic [CHANNELS-1:0] stageBits,
  input logic [CHANNELS-1:0] latchBits,
  input ctrlStrobes_t        strobes
);

  // Independent delay of the pins, matching the synchronizer latency.
  logic [SYNC_STAGES-1:0] oeDly, uvDly, otDly;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oeDly <= '0; uvDly <= '0; otDly <= '0;
    end else begin
      oeDly <= {oeDly[SYNC_STAGES-2:0], outEnN};
      uvDly <= {uvDly[SYNC_STAGES-2:0], uvFlag};
      otDly <= {otDly[SYNC_STAGES-2:0], otFlag};
    end
  end
  logic oeD, uvD, otD;
  assign oeD = oeDly[SYNC_STAGES-1];
  assign uvD = uvDly[SYNC_STAGES-1];
  assign otD = otDly[SYNC_STAGES-1];

  p_shift_move_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shift |=> stageBits[CHANNELS-1:1] == $past(stageBits[CHANNELS-2:0]));

  p_serout_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.shift && !strobes.clearAll) |=> $stable(serOut));

  p_latch_follow_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latchOpen |=> latchBits == $past(stageBits));

  p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.latchOpen && !strobes.clearAll) |=> $stable(latchBits));

  p_oe_blank_r6: assert property (@(posedge clk) disable iff (!rstN)
    oeD |-> chanOn == '0);

  p_pass_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!oeD && !uvD && !otD) |-> chanOn == latchBits);

  p_uv_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    uvD |=> (stageBits == '0 && latchBits == '0 && chanOn == '0));

  p_ot_blank_r9: assert property (@(posedge clk) disable iff (!rstN)
    otD |-> chanOn == '0);

endmodule

bind ledDrvCore ledDrvCoreChk #(.CHANNELS(CHANNELS), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .outEnN    (outEnN),
  .uvFlag    (uvFlag),
  .otFlag    (otFlag),
  .serOut    (serOut),
  .chanOn    (chanOn),
  .stageBits (stageBits),
  .latchBits (latchBits),
  .strobes   (strobes)
);

// File: tb/sim_ledDrvCore.sv
`timescale 1ns/1ps
module sim_ledDrvCore;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 16;
  localparam int HOLD       = 4;
  localparam int SETTLE     = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, latchEn = 1'b0, outEnN = 1'b0;
  logic uvFlag = 1'b0, otFlag = 1'b0;
  logic serOut;
  logic [N-1:0] chanOn;

  int compared = 0;
  int mismatched = 0;
  logic [N-1:0] modelSr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ledDrvCore u0 (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .latchEn(latchEn), .outEnN(outEnN), .uvFlag(uvFlag), .otFlag(otFlag),
    .serOut(serOut), .chanOn(chanOn)
  );

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic shiftBit(input logic b);
    serData = b;
    waitCyc(HOLD);
    serClk = 1'b1;
    waitCyc(HOLD);
    serClk = 1'b0;
    if (!uvFlag) modelSr = {modelSr[N-2:0], b};
    waitCyc(SETTLE);
  endtask

  task automatic loadWord(input logic [N-1:0] w);
    for (int i = N - 1; i >= 0; i--) shiftBit(w[i]);
  endtask

  task automatic pulseLatch();
    latchEn = 1'b1;
    waitCyc(HOLD);
    latchEn = 1'b0;
    waitCyc(SETTLE);
  endtask

  // R1
  task automatic t_reset();
    check("R1 chanOn after reset", chanOn, '0);
    check("R1 serOut after reset", {{(N-1){1'b0}}, serOut}, '0);
  endtask

  // R2, R7, R10
  task automatic t_loadShow();
    loadWord(16'hA5C3);
    check("R2 serOut is first bit shifted", {{(N-1){1'b0}}, serOut}, 16'h1);
    pulseLatch();
    check("R2 R7 R10 pattern shown", chanOn, 16'hA5C3);
    loadWord(16'h0001);
    pulseLatch();
    check("R7 single channel", chanOn, 16'h0001);
  endtask

  // R3
  task automatic t_cascade();
    loadWord(16'h8000);
    check("R3 top stage on serOut", {{(N-1){1'b0}}, serOut}, 16'h1);
    serData = 1'b0;
    waitCyc(SETTLE + HOLD);
    check("R3 serOut ignores serData alone", {{(N-1){1'b0}}, serOut}, 16'h1);
    shiftBit(1'b0);
    check("R3 serOut after one more edge", {{(N-1){1'b0}}, serOut}, 16'h0);
  endtask

  // R4
  task automatic t_transparent();
    latchEn = 1'b1;
    waitCyc(SETTLE);
    for (int k = 0; k < 5; k++) begin
      shiftBit(k[0]);
      check("R4 latch follows shifts", chanOn, modelSr);
    end
    latchEn = 1'b0;
    waitCyc(SETTLE);
  endtask

  // R5
  task automatic t_hold();
    logic [N-1:0] held;
    loadWord(16'h3C3C);
    pulseLatch();
    held = chanOn;
    check("R5 latched before hold", held, 16'h3C3C);
    loadWord(16'hFFFF);
    check("R5 latch holds while closed", chanOn, 16'h3C3C);
    pulseLatch();
    check("R5 new pattern after pulse", chanOn, 16'hFFFF);
  endtask

  // R6
  task automatic t_outEnable();
    loadWord(16'h5AA5);
    pulseLatch();
    outEnN = 1'b1;
    waitCyc(SETTLE);
    check("R6 outputs off when disabled", chanOn, '0);
    outEnN = 1'b0;
    waitCyc(SETTLE);
    check("R6 latch kept through disable", chanOn, 16'h5AA5);
  endtask

  // R8
  task automatic t_undervoltage();
    loadWord(16'hF00F);
    pulseLatch();
    check("R8 pattern before fault", chanOn, 16'hF00F);
    uvFlag = 1'b1;
    waitCyc(SETTLE);
    check("R8 outputs off in undervoltage", chanOn, '0);
    shiftBit(1'b1);
    uvFlag = 1'b0;
    waitCyc(SETTLE);
    modelSr = '0;
    check("R8 latches cleared on recovery", chanOn, '0);
    check("R8 serOut cleared on recovery", {{(N-1){1'b0}}, serOut}, '0);
    pulseLatch();
    check("R8 shift register cleared", chanOn, '0);
  endtask

  // R9
  task automatic t_overtemp();
    loadWord(16'h1234);
    pulseLatch();
    otFlag = 1'b1;
    waitCyc(SETTLE);
    check("R9 outputs off in overtemperature", chanOn, '0);
    loadWord(16'h8765);
    check("R9 shifting continues", {{(N-1){1'b0}}, serOut}, 16'h1);
    otFlag = 1'b0;
    waitCyc(SETTLE);
    check("R9 stored pattern resumes", chanOn, 16'h1234);
    pulseLatch();
    check("R9 data shifted during fault", chanOn, 16'h8765);
  endtask

  initial begin
    fork
      begin
        waitCyc(5);
        rstN = 1'b1;
        waitCyc(SETTLE);
        t_reset();
        t_loadShow();
        t_cascade();
        t_transparent();
        t_hold();
        t_outEnable();
        t_undervoltage();
        t_overtemp();
      end
      begin
        repeat (150000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule